// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the card bus clock of a memory-card host controller from the controller's own clock. Software programs a 16-bit rate word made of two fields. The upper field is a power-of-two prescaler. The lower field is a small integer divider. Separate control commands start the clock, stop it and return the block to its defaults. The block drives a toggled card clock, a one-cycle clock-enable pulse at the start of every card-clock period, and a flag that shows whether the clock is running.

Division takes two stages. The prescaler stage divides by 1 when its field is zero and by twice its value otherwise. The divider stage then divides by the divider value plus one. With the default widths, the fastest setting gives half the input clock and the slowest gives the input clock divided by 65536. Stopping is deferred to the end of a period, so the card never sees a shortened high or low phase. A rate written while the clock runs waits for the next period boundary before it takes effect.

Everything runs in one clock domain. The register writes are plain single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `card_clk_gen`

## Requirements
- R1: The rate word carries the prescaler p in bits 15:4 and the divider d in bits 3:0. With M = 1 when p = 0 and M = 2p otherwise, one card-clock period lasts (d+1)·M input cycles. For the first floor((d+1)/2)·M cycles the card clock is high, and for the rest it is low.
- R2: A divider field of 0 is stored and used as 1.
- R3: A prescaler field with more than one bit set is reduced to its most significant set bit. A field of 0 stays 0.
- R4: The control word has bit 0 = stop, bit 1 = start and bit 2 = soft reset. A start while the clock is idle begins a period in the very next cycle. In that cycle the card clock is high, the running flag is 1 and the enable pulse is 1.
- R5: A stop while the clock runs takes effect at the end of the current period, during its low phase. From then on the card clock stays low and the running flag is 0. Stop wins over start in the same write. A start while running cancels a pending stop and leaves the phase unchanged. A stop while idle has no effect.
- R6: A rate write made while the clock runs applies from the next period boundary. A rate write made while idle applies at the next start, and so does one made in the same cycle as that start.
- R7: A soft reset restores the rate to the DEF_RATE parameter and stops the clock at once. If the start bit is set in the same write and the stop bit is not, the clock restarts immediately at the default rate. A rate write in the same cycle is discarded.
- R8: The enable pulse is high for exactly one input cycle, the first cycle of each card-clock period, and only while the card clock is high.
- R9: After the reset pin is released, the card clock, the enable pulse and the running flag are 0, and the rate equals DEF_RATE.
- R10: Rate word 0x0001 gives a period of 2 input cycles, and 0x800F gives a period of 65536 input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 16 | Rate word: prescaler in 15:4, divider in 3:0 |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits: 0 stop, 1 start, 2 soft reset |
| card_clk | output | 1 | Toggled card bus clock |
| card_ce | output | 1 | One-cycle pulse at the start of each card-clock period |
| clk_running | output | 1 | High while the card clock runs |

## Verification
The bench keeps the default field widths, 12 prescaler bits and 4 divider bits. This puts both extremes of R10 in reach: the 2-cycle fastest period and the full 65536-cycle slowest period. It overrides DEF_RATE to 0x0013, which gives an 8-cycle period. A soft reset then leads to a short, easily measured period, and the reset-then-start sequence followed by repeated start writes can be checked quickly. Random rate words with small prescalers drive stop and start writes at arbitrary phases against the reference model.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // control word bit positions
  localparam int CTL_STOP  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_SRST  = 2;
  localparam int CTL_W     = 3;

  typedef struct packed {
    logic soft_rst;
    logic start;   // start without stop in the same write
    logic stop;
  } ccg_cmd_t;
endpackage

// File: rtl/ccg_regs.sv
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4,
  parameter logic [PRE_W+DIV_W-1:0] DEF_RATE = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rate_we,
  input  logic [PRE_W+DIV_W-1:0]  rate_wdata,
  input  logic                    ctl_we,
  input  logic [CTL_W-1:0]        ctl_wdata,
  output ccg_cmd_t                cmd,
  output logic [PRE_W-1:0]        nxt_pre,
  output logic [DIV_W-1:0]        nxt_div
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

  function automatic logic [PRE_W-1:0] keep_msb(input logic [PRE_W-1:0] v);
    logic [PRE_W-1:0] r;
    r = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [DIV_W-1:0] fix_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_MIN : v;
  endfunction

  localparam logic [PRE_W-1:0] DEF_PRE = keep_msb(DEF_RATE[PRE_W+DIV_W-1:DIV_W]);
  localparam logic [DIV_W-1:0] DEF_DIV = fix_div(DEF_RATE[DIV_W-1:0]);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    cmd.soft_rst = ctl_we & ctl_wdata[CTL_SRST];
    cmd.stop     = ctl_we & ctl_wdata[CTL_STOP];
    cmd.start    = ctl_we & ctl_wdata[CTL_START] & ~ctl_wdata[CTL_STOP];
  end

  always_comb begin
    nxt_pre = pre_q;
    nxt_div = div_q;
    if (cmd.soft_rst) begin
      nxt_pre = DEF_PRE;
      nxt_div = DEF_DIV;
    end else if (rate_we) begin
      nxt_pre = keep_msb(rate_wdata[PRE_W+DIV_W-1:DIV_W]);
      nxt_div = fix_div(rate_wdata[DIV_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= DEF_PRE;
      div_q <= DEF_DIV;
    end else begin
      pre_q <= nxt_pre;
      div_q <= nxt_div;
    end
  end

  assert_pre_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pre_q));
  assert_div_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q != '0);
  assert_srst_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.soft_rst |=> (pre_q == DEF_PRE && div_q == DEF_DIV));
endmodule

// File: rtl/ccg_prescale.sv
module ccg_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam logic [PRE_W-1:0] P_ONE = PRE_W'(1);

  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] lim;

  // terminal count is 2*pre-1; for pre = 2^(PRE_W-1) it wraps to all ones
  assign lim  = (pre == '0) ? '0 : ({pre[PRE_W-2:0], 1'b0} - P_ONE);
  assign tick = ~clr & (pc_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= '0;
    else if (clr||tick) pc_q <= '0;
    else                pc_q <= pc_q + P_ONE;
  end

  assert_pc_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (pc_q <= lim));
endmodule

// File: rtl/ccg_divide.sv
module ccg_divide
  import ccg_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ccg_cmd_t         cmd,
  input  logic             tick,
  input  logic [PRE_W-1:0] nxt_pre,
  input  logic [DIV_W-1:0] nxt_div,
  output logic [PRE_W-1:0] act_pre,
  output logic             card_clk,
  output logic             card_ce,
  output logic             running
);
  localparam logic [DIV_W-1:0] DC_ONE = DIV_W'(1);
  localparam logic [DIV_W:0]   H_ONE  = (DIV_W+1)'(1);

  logic             run_q, run_n, spend_q, spend_n;
  logic [PRE_W-1:0] apre_q, apre_n;
  logic [DIV_W-1:0] adiv_q, adiv_n, dc_q, dc_n;
  logic             cclk_q, cclk_n, ce_q, ce_n;
  logic [DIV_W:0]   half_n;

  always_comb begin
    run_n   = run_q;
    spend_n = spend_q;
    apre_n  = apre_q;
    adiv_n  = adiv_q;
    dc_n    = dc_q;
    ce_n    = 1'b0;
    if (cmd.soft_rst) begin
      spend_n = 1'b0;
      dc_n    = '0;
      run_n   = cmd.start;
      apre_n  = nxt_pre;
      adiv_n  = nxt_div;
      ce_n    = cmd.start;
    end else if (!run_q) begin
      if (cmd.start) begin
        run_n  = 1'b1;
        dc_n   = '0;
        apre_n = nxt_pre;
        adiv_n = nxt_div;
        ce_n   = 1'b1;
      end
    end else begin
      if (cmd.stop)       spend_n = 1'b1;
      else if (cmd.start) spend_n = 1'b0;
      if (tick) begin
        if (dc_q == adiv_q) begin
          dc_n = '0;
          if (spend_n) begin
            run_n   = 1'b0;
            spend_n = 1'b0;
          end else begin
            apre_n = nxt_pre;
            adiv_n = nxt_div;
            ce_n   = 1'b1;
          end
        end else begin
          dc_n = dc_q + DC_ONE;
        end
      end
    end
    half_n = ({1'b0, adiv_n} + H_ONE) >> 1;
    cclk_n = run_n & ({1'b0, dc_n} < half_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      spend_q <= 1'b0;
      apre_q  <= '0;
      adiv_q  <= DC_ONE;
      dc_q    <= '0;
      cclk_q  <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      run_q   <= run_n;
      spend_q <= spend_n;
      apre_q  <= apre_n;
      adiv_q  <= adiv_n;
      dc_q    <= dc_n;
      cclk_q  <= cclk_n;
      ce_q    <= ce_n;
    end
  end

  assign act_pre  = apre_q;
  assign card_clk = cclk_q;
  assign card_ce  = ce_q;
  assign running  = run_q;

  assert_div_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q <= adiv_q);
  assert_start_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cmd.start) |=> (run_q && cclk_q && ce_q));
  assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(run_q) && !$past(cmd.soft_rst)) |-> !$past(cclk_q));
  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !cmd.soft_rst) |=> ($stable(adiv_q) && $stable(apre_q)));
  assert_ce_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> (cclk_q && run_q));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ccg_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4,
  parameter logic [PRE_W+DIV_W-1:0] DEF_RATE = 16'h800F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rate_we,
  input  logic [PRE_W+DIV_W-1:0] rate_wdata,
  input  logic                   ctl_we,
  input  logic [CTL_W-1:0]       ctl_wdata,
  output logic                   card_clk,
  output logic                   card_ce,
  output logic                   clk_running
);
  ccg_cmd_t         cmd;
  logic [PRE_W-1:0] nxt_pre, act_pre;
  logic [DIV_W-1:0] nxt_div;
  logic             tick, pc_clr;

  ccg_regs #(.PRE_W(PRE_W), .DIV_W(DIV_W), .DEF_RATE(DEF_RATE)) u_regs (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cmd(cmd),
    .nxt_pre(nxt_pre), .nxt_div(nxt_div)
  );

  assign pc_clr = cmd.soft_rst | ~clk_running;

  ccg_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pc_clr), .pre(act_pre), .tick(tick)
  );

  ccg_divide #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(tick),
    .nxt_pre(nxt_pre), .nxt_div(nxt_div), .act_pre(act_pre),
    .card_clk(card_clk), .card_ce(card_ce), .running(clk_running)
  );

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!card_clk && !clk_running));
endmodule

// File: tb/sim_card_clk_gen.sv
module sim_card_clk_gen;
  localparam logic [15:0] TB_DEF = 16'h0013;
  localparam int WDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rate_we = 1'b0, ctl_we = 1'b0;
  logic [15:0] rate_wdata = '0;
  logic [2:0]  ctl_wdata = '0;
  logic card_clk, card_ce, clk_running;

  int tests = 0, fails = 0, cyc = 0;
  string req_tag = "R9";

  card_clk_gen #(.DEF_RATE(TB_DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .card_clk(card_clk),
    .card_ce(card_ce), .clk_running(clk_running)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic int npre(int f);
    int r = 0;
    for (int i = 0; i < 12; i++) if (f[i]) r = 1 << i;
    return r;
  endfunction
  function automatic int ndiv(int f);
    return (f == 0) ? 1 : f;
  endfunction
  function automatic int mult(int p);
    return (p == 0) ? 1 : 2 * p;
  endfunction

  int m_run, m_spend, m_pre, m_div, a_pre, a_div, m_pos, m_ce;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_spend = 0; m_pos = 0; m_ce = 0;
      m_pre = npre(int'(TB_DEF[15:4])); m_div = ndiv(int'(TB_DEF[3:0]));
      a_pre = m_pre; a_div = m_div;
    end else if (ctl_we && ctl_wdata[2]) begin
      m_pre = npre(int'(TB_DEF[15:4])); m_div = ndiv(int'(TB_DEF[3:0]));
      m_run = (ctl_wdata[1] && !ctl_wdata[0]) ? 1 : 0;
      m_spend = 0; m_pos = 0; a_pre = m_pre; a_div = m_div; m_ce = m_run;
    end else begin
      if (rate_we) begin
        m_pre = npre(int'(rate_wdata[15:4])); m_div = ndiv(int'(rate_wdata[3:0]));
      end
      m_ce = 0;
      if (m_run == 0) begin
        if (ctl_we && ctl_wdata[1] && !ctl_wdata[0]) begin
          m_run = 1; m_pos = 0; a_pre = m_pre; a_div = m_div; m_ce = 1;
        end
      end else begin
        if (ctl_we && ctl_wdata[0]) m_spend = 1;
        else if (ctl_we && ctl_wdata[1]) m_spend = 0;
        if (m_pos == (a_div + 1) * mult(a_pre) - 1) begin
          m_pos = 0;
          if (m_spend != 0) begin m_run = 0; m_spend = 0; end
          else begin a_pre = m_pre; a_div = m_div; m_ce = 1; end
        end else m_pos++;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int e_clk = (m_run != 0 && m_pos < ((a_div + 1) / 2) * mult(a_pre)) ? 1 : 0;
      tests++;
      if (int'(card_clk) != e_clk || int'(card_ce) != m_ce || int'(clk_running) != m_run) begin
        fails++;
        $display("FAIL %s cycle %0d clk/ce/run actual %0d%0d%0d expected %0d%0d%0d",
                 req_tag, cyc, card_clk, card_ce, clk_running, e_clk, m_ce, m_run);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG) begin
      fails++;
      $display("FAIL watchdog %s actual %0d cycles expected fewer than %0d", req_tag, cyc, WDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_rate(input logic [15:0] v);
    @(negedge clk); rate_we = 1'b1; rate_wdata = v;
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_ce();
    do @(negedge clk); while (!card_ce);
  endtask

  // measure one full period starting at the next enable pulse
  task automatic measure(input int ep, input int eh, input string tag);
    int p = 0, h = 0;
    wait_ce();
    do begin
      if (card_clk) h++;
      p++;
      @(negedge clk);
    end while (!card_ce && p < 70000);
    chk(p == ep, {tag, " period"}, p, ep);
    chk(h == eh, {tag, " high phase"}, h, eh);
  endtask

  task automatic wait_stopped();
    int n = 0;
    while (clk_running && n < 70000) begin @(negedge clk); n++; end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_tag = "R9";
    chk(card_clk == 1'b0, "R9 card_clk after reset", card_clk, 0);
    chk(clk_running == 1'b0, "R9 running after reset", clk_running, 0);
    chk(card_ce == 1'b0, "R9 enable after reset", card_ce, 0);

    req_tag = "R9";
    wr_ctl(3'b010);                          // start at default rate 0x0013
    measure(8, 4, "R9 default rate");

    req_tag = "R5";
    wr_ctl(3'b001);
    wait_stopped();
    chk(card_clk == 1'b0, "R5 clock low after stop", card_clk, 0);
    repeat (5) @(negedge clk);
    chk(clk_running == 1'b0, "R5 stays stopped", clk_running, 0);

    req_tag = "R10";
    wr_rate(16'h0001);
    wr_ctl(3'b010);
    measure(2, 1, "R10 fastest");

    req_tag = "R6";
    wr_rate(16'h0002);                       // while running: next boundary
    measure(3, 1, "R6 odd divider");
    wr_ctl(3'b001); wait_stopped();

    req_tag = "R2";
    wr_rate(16'h0020);                       // p=2 M=4, d=0 -> 1
    wr_ctl(3'b010);
    measure(8, 4, "R2 divider zero");
    req_tag = "R3";
    wr_rate(16'h0035);                       // p=3 -> 2, M=4, d=5
    measure(24, 12, "R3 prescaler msb");

    req_tag = "R6";
    wait_ce();
    @(negedge clk);
    rate_we = 1'b1; rate_wdata = 16'h0001;
    @(negedge clk); rate_we = 1'b0;
    begin
      int p = 2;
      while (!card_ce && p < 100) begin @(negedge clk); p++; end
      chk(p == 24, "R6 current period unchanged", p, 24);
    end
    measure(2, 1, "R6 new rate after boundary");

    req_tag = "R5";
    wr_rate(16'h0013);
    wait_ce();
    wr_ctl(3'b001);                          // stop pending
    wr_ctl(3'b010);                          // start cancels it
    repeat (40) @(negedge clk);
    chk(clk_running == 1'b1, "R5 start cancels stop", clk_running, 1);
    wr_ctl(3'b011);                          // stop wins
    wait_stopped();
    wr_ctl(3'b011);
    repeat (4) @(negedge clk);
    chk(clk_running == 1'b0, "R5 stop+start while idle", clk_running, 0);
    wr_ctl(3'b001);
    chk(clk_running == 1'b0, "R5 stop while idle", clk_running, 0);

    req_tag = "R4";
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 3'b010;
    @(negedge clk); ctl_we = 1'b0;
    chk(card_clk && card_ce && clk_running, "R4 start next cycle",
        {card_clk, card_ce, clk_running}, 7);

    req_tag = "R7";
    wr_rate(16'h0047);
    measure(64, 32, "R7 pre-reset rate");
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 3'b100;
    rate_we = 1'b1; rate_wdata = 16'h0001;
    @(negedge clk); ctl_we = 1'b0; rate_we = 1'b0;
    chk(clk_running == 1'b0 && card_clk == 1'b0, "R7 soft reset stops",
        {clk_running, card_clk}, 0);
    wr_ctl(3'b100);
    wr_ctl(3'b110);
    for (int i = 0; i < 8; i++) wr_ctl(3'b010);
    measure(8, 4, "R7 restart at default rate");

    req_tag = "R8";
    repeat (30) begin
      wr_ctl(3'b010);                        // starts while running: no phase change
      @(negedge clk);
    end
    measure(8, 4, "R8 period after start writes");

    req_tag = "R1";
    for (int i = 0; i < 30; i++) begin
      automatic int r = $urandom;
      wr_rate({8'h00, r[7:0]});
      wr_ctl(r[9:8] == 2'b00 ? 3'b011 : {1'b0, r[9:8]});
      repeat (r[17:10]) @(negedge clk);
    end

    req_tag = "R10";
    wr_ctl(3'b100);
    wr_rate(16'h800F);
    wr_ctl(3'b010);
    measure(65536, 32768, "R10 slowest");
    wr_ctl(3'b100);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule